// File: doc/BRIEF.md
# Descriptor Chain DMA Channel with Counting Semaphore

This block is one DMA channel engine. It executes command descriptors that it reads from memory, one after another. A counting semaphore starts and stops the channel. Software first writes the address of the first descriptor into a pointer register. It then writes a count into the semaphore. While the semaphore is non-zero and the pointer is valid, the engine does four things in turn for each descriptor:

- it fetches the descriptor,
- it runs the transfer by counting down the length, one word per cycle in which the data side is ready,
- it signals completion,
- it decides where to continue.

A descriptor is three 32-bit words at consecutive word addresses, fetched in this order:

- **Control word:** bit 0 = chain, bit 1 = decrement semaphore, bit 2 = interrupt on completion, bits 31:16 = transfer length in words.
- **Next-descriptor address.**
- **Buffer address.**

When a finished command has the chain flag set, its next-descriptor address becomes the new pointer. When the chain flag is clear, the pointer becomes invalid and the engine waits until software writes the pointer again. Writing the semaphore always adds to the outstanding count, so work can be queued while the channel runs.

Register map (selected by the 2-bit address):

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | Descriptor pointer | Current pointer | Loads the pointer and marks it valid |
| 1 | Semaphore | Current count | Adds the written value to the count |
| 2 | Status | bit 0 = command done, bit 1 = alignment error, bit 2 = interrupt pending | Write 1 to clear a bit |

Top module: `desc_chain_dma`

## Requirements
- R1: After reset the semaphore reads 0, status reads 0, and `mem_req`, `xfer_active`, `cmd_done` and `irq` are low.
- R2: No descriptor fetch starts unless the semaphore is non-zero and the pointer has been written since reset or since the last unchained completion.
- R3: A started descriptor is fetched as three reads at pointer, pointer+4 and pointer+8, in that order.
- R4: A transfer of length L asserts `xfer_active` until L cycles with `xfer_ready` high have passed. `xfer_addr` starts at the buffer address, steps by 4 per accepted word, and holds while `xfer_ready` is low.
- R5: Every completed command gives a one-cycle `cmd_done` pulse and sets status bit 0. Writing 1 to a status bit clears it.
- R6: A completed command decrements the semaphore by one only when its control bit 1 is set. Otherwise the count is unchanged.
- R7: After a command with control bit 0 set, the next fetch starts at that command's next-descriptor address, if the semaphore is still non-zero. The channel halts when the count reaches zero.
- R8: After a command with control bit 0 clear, no further fetch happens, even with a non-zero semaphore, until the pointer register is written again.
- R9: A semaphore write while the channel is running adds the written value to the outstanding count, and the queued chained commands then run.
- R10: A completed command with control bit 2 set raises status bit 2 and `irq`. Both stay high until cleared by writing 1 to status bit 2.
- R11: A pointer with either of bits 1:0 set is refused: status bit 1 is set, nothing is fetched, the semaphore is kept, and the channel waits for a new pointer write.
- R12: Reading the semaphore returns the number of commands accepted but not yet finished. It reads 0 once a fully decrementing chain has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Register write address |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 2 | Register read address |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_valid | input | 1 | Read data valid; accepts the current request |
| mem_data | input | 32 | Read data |
| xfer_ready | input | 1 | Data side can take one word this cycle |
| xfer_active | output | 1 | A transfer word is pending |
| xfer_addr | output | 32 | Buffer address of the pending word |
| cmd_done | output | 1 | One-cycle pulse per completed command |
| irq | output | 1 | Interrupt-pending status level |

## Verification
The semaphore count is shown directly at the semaphore read port, so a wrong increment or decrement is visible on the next read after the completing cycle. A stale or wrong pointer shows up at the first `mem_req` of the following descriptor, as an out-of-order or unexpected fetch address. A wrong transfer counter shows up at once as an extra or missing `xfer_active` cycle, or as a wrong `xfer_addr` in the word-by-word log. A wrong completion decision (continue, halt or wait for a new pointer) shows up within a few cycles as fetches that appear or are missing in the bench's fetch log.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_XFER,
        ST_DONE
    } dcd_state_e;

    // control word bit positions (decoded by the engine)
    localparam int CTL_CHAIN   = 0;
    localparam int CTL_DEC     = 1;
    localparam int CTL_IRQ     = 2;
    localparam int CTL_LEN_LSB = 16;

    // register addresses
    localparam logic [1:0] RA_PTR  = 2'd0;
    localparam logic [1:0] RA_SEMA = 2'd1;
    localparam logic [1:0] RA_STAT = 2'd2;
endpackage

// File: rtl/dcd_sema_ctr.sv
module dcd_sema_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] count,
    output logic             nonzero
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (add_en) begin
            cnt_d = cnt_d + add_val;
        end
        if (dec_en) begin
            cnt_d = cnt_d - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count   = cnt_q;
    assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/dcd_xfer_ctr.sv
module dcd_xfer_ctr #(
    parameter int LEN_W = 16,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic [AW-1:0]    load_addr,
    input  logic             step_ok,
    output logic             busy,
    output logic [AW-1:0]    cur_addr
);
    localparam logic [AW-1:0]    STRIDE = {{(AW-3){1'b0}}, 3'd4};
    localparam logic [LEN_W-1:0] ONE    = {{(LEN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [LEN_W-1:0] rem;
        logic [AW-1:0]    addr;
    } xs_t;

    xs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.rem  = load_len;
            s_d.addr = load_addr;
        end else if (step_ok && (s_q.rem != '0)) begin
            s_d.rem  = s_q.rem - ONE;
            s_d.addr = s_q.addr + STRIDE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.rem != '0);
    assign cur_addr = s_q.addr;
endmodule

// File: rtl/desc_chain_dma.sv
module desc_chain_dma
    import dcd_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_W  = 16,
    parameter int SEMA_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [1:0]    cfg_wr_addr,
    input  logic [31:0]   cfg_wr_data,
    input  logic [1:0]    cfg_rd_addr,
    output logic [31:0]   cfg_rd_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [31:0]   mem_data,
    input  logic          xfer_ready,
    output logic          xfer_active,
    output logic [AW-1:0] xfer_addr,
    output logic          cmd_done,
    output logic          irq
);
    localparam int IDX_W = 2;

    typedef struct packed {
        dcd_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    ptr;
        logic             ptr_vld;
        logic [AW-1:0]    base;
        logic             c_chain;
        logic             c_dec;
        logic             c_irq;
        logic [LEN_W-1:0] len;
        logic [AW-1:0]    nxt;
        logic             done_s;
        logic             err_s;
        logic             irq_s;
    } eng_t;

    eng_t r_d, r_q;

    logic              wr_ptr, wr_sema, wr_stat;
    logic              sema_dec;
    logic [SEMA_W-1:0] sema_cnt;
    logic              sema_nz;
    logic              xfer_load;
    logic              xfer_busy;
    logic              xfer_step;

    assign wr_ptr  = cfg_wr_en && (cfg_wr_addr == RA_PTR);
    assign wr_sema = cfg_wr_en && (cfg_wr_addr == RA_SEMA);
    assign wr_stat = cfg_wr_en && (cfg_wr_addr == RA_STAT);

    dcd_sema_ctr #(.CNT_W(SEMA_W)) sema_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (wr_sema),
        .add_val (cfg_wr_data[SEMA_W-1:0]),
        .dec_en  (sema_dec),
        .count   (sema_cnt),
        .nonzero (sema_nz)
    );

    assign xfer_step = (r_q.st == ST_XFER) && xfer_ready;

    dcd_xfer_ctr #(.LEN_W(LEN_W), .AW(AW)) xfer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (xfer_load),
        .load_len  (r_q.len),
        .load_addr (mem_data[AW-1:0]),
        .step_ok   (xfer_step),
        .busy      (xfer_busy),
        .cur_addr  (xfer_addr)
    );

    always_comb begin
        r_d       = r_q;
        xfer_load = 1'b0;
        sema_dec  = 1'b0;

        // status clears first so that same-cycle sets win
        if (wr_stat) begin
            if (cfg_wr_data[0]) r_d.done_s = 1'b0;
            if (cfg_wr_data[1]) r_d.err_s  = 1'b0;
            if (cfg_wr_data[2]) r_d.irq_s  = 1'b0;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (r_q.ptr_vld && sema_nz) begin
                    if (r_q.ptr[1:0] != 2'b00) begin
                        r_d.err_s   = 1'b1;
                        r_d.ptr_vld = 1'b0;
                    end else begin
                        r_d.st   = ST_FETCH;
                        r_d.idx  = '0;
                        r_d.base = r_q.ptr;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_valid) begin
                    r_d.idx = r_q.idx + 2'd1;
                    case (r_q.idx)
                        2'd0: begin
                            r_d.c_chain = mem_data[CTL_CHAIN];
                            r_d.c_dec   = mem_data[CTL_DEC];
                            r_d.c_irq   = mem_data[CTL_IRQ];
                            r_d.len     = mem_data[CTL_LEN_LSB +: LEN_W];
                        end
                        2'd1: begin
                            r_d.nxt = mem_data[AW-1:0];
                        end
                        default: begin
                            xfer_load = 1'b1;
                            r_d.st    = ST_XFER;
                        end
                    endcase
                end
            end
            ST_XFER: begin
                if (!xfer_busy) begin
                    r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st     = ST_IDLE;
                r_d.done_s = 1'b1;
                sema_dec   = r_q.c_dec;
                if (r_q.c_irq) begin
                    r_d.irq_s = 1'b1;
                end
                if (r_q.c_chain) begin
                    r_d.ptr = r_q.nxt;
                end else begin
                    r_d.ptr_vld = 1'b0;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        // a software pointer write overrides any engine update
        if (wr_ptr) begin
            r_d.ptr     = cfg_wr_data[AW-1:0];
            r_d.ptr_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req     = (r_q.st == ST_FETCH);
    assign mem_addr    = r_q.base + {{(AW-4){1'b0}}, r_q.idx, 2'b00};
    assign xfer_active = (r_q.st == ST_XFER) && xfer_busy;
    assign cmd_done    = (r_q.st == ST_DONE);
    assign irq         = r_q.irq_s;

    always_comb begin
        case (cfg_rd_addr)
            RA_PTR:  cfg_rd_data = 32'(r_q.ptr);
            RA_SEMA: cfg_rd_data = 32'(sema_cnt);
            RA_STAT: cfg_rd_data = {29'd0, r_q.irq_s, r_q.err_s, r_q.done_s};
            default: cfg_rd_data = 32'd0;
        endcase
    end
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
    import dcd_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SEMA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [1:0]        cfg_wr_addr,
    input logic              mem_req,
    input logic [AW-1:0]     mem_addr,
    input logic              xfer_active,
    input logic              xfer_ready,
    input logic [AW-1:0]     xfer_addr,
    input logic              cmd_done,
    input logic              irq,
    input logic [SEMA_W-1:0] sema_cnt
);
    logic sema_wr;
    assign sema_wr = cfg_wr_en && (cfg_wr_addr == RA_SEMA);

    assert_fetch_needs_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (sema_cnt != '0));

    assert_fetch_word_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    assert_fetch_xfer_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && xfer_active));

    assert_xfer_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !xfer_ready) |=> $stable(xfer_addr));

    assert_done_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_sema_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sema_wr |=> (sema_cnt <= $past(sema_cnt)));

    assert_sema_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sema_wr && !cmd_done) |=> (sema_cnt == $past(sema_cnt)));

    assert_irq_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_done));
endmodule

bind desc_chain_dma dcd_checker #(.AW(AW), .SEMA_W(SEMA_W)) chk_i (.*);

// File: tb/desc_chain_dma_tb_top.sv
module desc_chain_dma_tb_top;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_addr = 2'd0;
    logic [31:0] cfg_wr_data = 32'd0;
    logic [1:0]  cfg_rd_addr = 2'd0;
    logic [31:0] cfg_rd_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid;
    logic [31:0] mem_data;
    logic        xfer_ready = 1'b1;
    logic        xfer_active;
    logic [31:0] xfer_addr;
    logic        cmd_done;
    logic        irq;

    always #5 clk = ~clk;

    logic [31:0] mem [0:255];
    assign mem_valid = mem_req;
    assign mem_data  = mem[mem_addr[9:2]];

    desc_chain_dma dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
        .xfer_ready(xfer_ready), .xfer_active(xfer_active), .xfer_addr(xfer_addr),
        .cmd_done(cmd_done), .irq(irq)
    );

    // monitors: monotonic logs
    int          fcnt = 0;
    int          xcnt = 0;
    int          dcnt = 0;
    logic [31:0] flog [0:511];
    logic [31:0] xlog [0:511];

    always @(negedge clk) begin
        if (rst_n && mem_req && mem_valid) begin
            flog[fcnt[8:0]] <= mem_addr;
            fcnt <= fcnt + 1;
        end
        if (rst_n && xfer_active && xfer_ready) begin
            xlog[xcnt[8:0]] <= xfer_addr;
            xcnt <= xcnt + 1;
        end
        if (rst_n && cmd_done) dcnt <= dcnt + 1;
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        cfg_rd_addr = a;
        #1;
        v = cfg_rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic put_desc(input int a, input logic [31:0] c, input logic [31:0] n, input logic [31:0] b);
        mem[a/4]     = c;
        mem[a/4 + 1] = n;
        mem[a/4 + 2] = b;
    endtask

    task automatic wait_done(input int target);
        for (int k = 0; k < 600 && dcnt < target; k++) @(negedge clk);
    endtask

    typedef struct packed {
        logic [31:0] ctrl;
        logic [7:0]  exp_sema;
        logic [2:0]  exp_stat;
    } vec_t;

    // ctrl: len<<16 | irq<<2 | dec<<1 | chain
    localparam vec_t VECS [0:5] = '{
        '{32'h0003_0002, 8'd0, 3'b001},
        '{32'h0000_0006, 8'd0, 3'b101},
        '{32'h0005_0000, 8'd1, 3'b001},
        '{32'h0001_0006, 8'd0, 3'b101},
        '{32'h0002_0003, 8'd0, 3'b001},
        '{32'h0007_0004, 8'd1, 3'b101}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int f0, x0, d0;
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        do_reset();

        // R1: reset state
        rd(2'd1, v); chk(v == 0, "R1 sema", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 status", v, 0);
        chk({mem_req, xfer_active, cmd_done, irq} == 4'b0, "R1 outputs",
            {mem_req, xfer_active, cmd_done, irq}, 0);

        // R2: semaphore without a pointer, then a pointer without... order
        put_desc(32'h40, 32'h0001_0002, 32'h0, 32'h2000);
        f0 = fcnt;
        wr(2'd1, 32'd1);
        repeat (10) @(negedge clk);
        chk(fcnt == f0, "R2 no fetch without pointer", fcnt - f0, 0);
        wr(2'd0, 32'h40);
        wait_done(1);
        chk(fcnt - f0 == 3, "R2 fetch after pointer", fcnt - f0, 3);

        // table walk
        for (int i = 0; i < 6; i++) begin
            int len;
            logic [31:0] buf_a;
            len   = int'(VECS[i].ctrl[31:16]);
            buf_a = 32'h1000 + 32'(i) * 32'h100;
            do_reset();
            put_desc(32'h40, VECS[i].ctrl, 32'h80, buf_a);
            f0 = fcnt; x0 = xcnt; d0 = dcnt;
            wr(2'd0, 32'h40);
            wr(2'd1, 32'd1);
            wait_done(d0 + 1);
            repeat (10) @(negedge clk);
            chk(fcnt - f0 == 3, "R3/R8 fetch count", fcnt - f0, 3);
            chk(flog[f0[8:0]] == 32'h40 && flog[(f0 + 2) & 511] == 32'h48, "R3 fetch order",
                flog[(f0 + 2) & 511], 32'h48);
            chk(xcnt - x0 == len, "R4 transfer words", xcnt - x0, len);
            if (len > 0)
                chk(xlog[x0[8:0]] == buf_a && xlog[(x0 + len - 1) & 511] == buf_a + 32'(4 * (len - 1)),
                    "R4 transfer addresses", xlog[(x0 + len - 1) & 511], buf_a + 32'(4 * (len - 1)));
            chk(dcnt - d0 == 1, "R5 single done pulse", dcnt - d0, 1);
            rd(2'd1, v); chk(v == 32'(VECS[i].exp_sema), "R6 semaphore after command", v, 32'(VECS[i].exp_sema));
            rd(2'd2, v); chk(v == 32'(VECS[i].exp_stat), "R5/R10 status", v, 32'(VECS[i].exp_stat));
            chk(irq == VECS[i].exp_stat[2], "R10 irq level", irq, VECS[i].exp_stat[2]);
        end

        // R7/R12: chain of three
        do_reset();
        put_desc(32'h40, 32'h0001_0003, 32'h50, 32'h3000);
        put_desc(32'h50, 32'h0002_0003, 32'h60, 32'h3100);
        put_desc(32'h60, 32'h0001_0002, 32'h00, 32'h3200);
        f0 = fcnt; d0 = dcnt;
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd3);
        wait_done(d0 + 3);
        repeat (10) @(negedge clk);
        chk(fcnt - f0 == 9, "R7 chain fetch count", fcnt - f0, 9);
        chk(flog[(f0 + 3) & 511] == 32'h50 && flog[(f0 + 6) & 511] == 32'h60 && flog[(f0 + 8) & 511] == 32'h68,
            "R7 chain addresses", flog[(f0 + 6) & 511], 32'h60);
        rd(2'd1, v); chk(v == 0, "R12 semaphore zero after chain", v, 0);

        // R9: add while running
        do_reset();
        put_desc(32'h40, 32'h0014_0003, 32'h50, 32'h4000);
        put_desc(32'h50, 32'h0002_0002, 32'h00, 32'h4100);
        f0 = fcnt; x0 = xcnt; d0 = dcnt;
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd1);
        for (int k = 0; k < 100 && xcnt < x0 + 4; k++) @(negedge clk);
        wr(2'd1, 32'd1);
        rd(2'd1, v); chk(v == 2, "R9/R12 semaphore after add", v, 2);
        wait_done(d0 + 2);
        repeat (10) @(negedge clk);
        chk(dcnt - d0 == 2, "R9 queued command ran", dcnt - d0, 2);
        rd(2'd1, v); chk(v == 0, "R12 semaphore drained", v, 0);

        // R8: unchained stop with count left
        do_reset();
        put_desc(32'h40, 32'h0001_0002, 32'h50, 32'h5000);
        put_desc(32'h70, 32'h0001_0002, 32'h00, 32'h5100);
        f0 = fcnt; d0 = dcnt;
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd2);
        wait_done(d0 + 1);
        repeat (15) @(negedge clk);
        chk(fcnt - f0 == 3, "R8 waits for pointer", fcnt - f0, 3);
        rd(2'd1, v); chk(v == 1, "R8 count kept", v, 1);
        wr(2'd0, 32'h70);
        wait_done(d0 + 2);
        repeat (5) @(negedge clk);
        chk(flog[(f0 + 3) & 511] == 32'h70, "R8 resumes at new pointer", flog[(f0 + 3) & 511], 32'h70);
        rd(2'd1, v); chk(v == 0, "R8 count drained", v, 0);

        // R11: misaligned pointer
        do_reset();
        put_desc(32'h40, 32'h0001_0002, 32'h00, 32'h6000);
        f0 = fcnt; d0 = dcnt;
        wr(2'd0, 32'h42);
        wr(2'd1, 32'd1);
        repeat (10) @(negedge clk);
        chk(fcnt == f0, "R11 no fetch", fcnt - f0, 0);
        rd(2'd2, v); chk(v == 32'd2, "R11 error bit", v, 2);
        rd(2'd1, v); chk(v == 1, "R11 count kept", v, 1);
        wr(2'd2, 32'd2);
        rd(2'd2, v); chk(v == 0, "R5 write-one clear", v, 0);
        wr(2'd0, 32'h40);
        wait_done(d0 + 1);
        chk(dcnt - d0 == 1, "R11 recovers on new pointer", dcnt - d0, 1);

        // R4: stall
        do_reset();
        put_desc(32'h40, 32'h0004_0002, 32'h00, 32'h7000);
        x0 = xcnt; d0 = dcnt;
        xfer_ready = 1'b0;
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd1);
        repeat (15) @(negedge clk);
        chk(xfer_active && xfer_addr == 32'h7000, "R4 stalled holds", xfer_addr, 32'h7000);
        xfer_ready = 1'b1;
        wait_done(d0 + 1);
        chk(xcnt - x0 == 4 && xlog[(x0 + 3) & 511] == 32'h700C, "R4 words after stall",
            xlog[(x0 + 3) & 511], 32'h700C);

        // R10: clear irq
        do_reset();
        put_desc(32'h40, 32'h0000_0006, 32'h00, 32'h8000);
        d0 = dcnt;
        wr(2'd0, 32'h40);
        wr(2'd1, 32'd1);
        wait_done(d0 + 1);
        repeat (3) @(negedge clk);
        chk(irq == 1'b1, "R10 irq set", irq, 1);
        wr(2'd2, 32'd4);
        rd(2'd2, v);
        chk(irq == 1'b0 && v == 32'd1, "R10 irq cleared, done kept", v, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule